// File: doc/BRIEF.md
# Split-Register 32-Input Interrupt Unit

This block watches a bank of general-purpose input pins and turns their activity into interrupt requests. Each pin runs through a two-flop synchronizer, then through a per-pin detector. The detector can work as a level detector of either polarity or as an edge detector, with rising and falling edges enabled separately. A per-pin status bit either latches a detected event until software clears it (hold mode) or follows the detector from cycle to cycle (through mode).

Every configuration and status field is 16 bits wide. With the default width, the 32 pins are split across a low register, which holds pins 0 to 15, and a high register, which holds pins 16 to 31. A status bit that is set and whose enable bit is also set counts as pending. Any pending pin raises the interrupt output. A fixed-priority encoder names the lowest-numbered pending pin, so every low-half pin wins over every high-half pin. When software claims an interrupt while nothing is pending, the block flags the request as spurious.

Register access uses plain pins. A write is a single-cycle strobe with an address and 16 data bits, and it takes effect on the next clock edge. A read is combinational from the read address. Control and status stay plain signals: no stream traffic passes through this block, so the ports have no valid/ready handshake and no back-pressure.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every configuration and status field reads 0, irq_o is low and irq_valid_o is low.
- R2: Register map, using byte addresses, with the low register first and then the high register: status 0x08/0x0A, enable 0x0C/0x0E, trigger type 0x10/0x12, level polarity 0x14/0x16, hold select 0x18/0x1A, falling-edge enable 0x20/0x22, rising-edge enable 0x24/0x26. Pin p sits at bit p of the low register when p < 16, and at bit p-16 of the high register otherwise. Every other address reads 0, and a write to it changes nothing.
- R3: A trigger-type bit of 0 selects level detection. A polarity bit of 1 makes a high input active; a polarity bit of 0 makes a low input active.
- R4: A trigger-type bit of 1 selects edge detection. A 0-to-1 input change is detected only when the rising-edge enable is 1. A 1-to-0 change is detected only when the falling-edge enable is 1. With both enables set, both edges are detected.
- R5: In hold mode (hold bit 1), a detected event sets the status bit, and the bit stays set until a write of 1 to that bit position at a status address. A written 0 leaves the bit unchanged.
- R6: In through mode (hold bit 0), the status bit equals the detector output of the previous cycle, so a detected edge shows as a one-cycle status pulse.
- R7: A pin is pending when its status bit and its enable bit are both 1. irq_o is high exactly when at least one pin is pending. A status bit that is set while its enable bit is 0 has no effect on irq_o.
- R8: irq_id_o gives the lowest-numbered pending pin, so pins 0..15 win over pins 16..31. irq_valid_o is high whenever a pin is pending.
- R9: spurious_o is high when claim_i is high and no pin is pending, and is low otherwise.
- R10: An input change made just before clock edge k reaches the status bit at edge k+2, and is not visible before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Raw input pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 16 | Combinational read data |
| claim_i | input | 1 | Software claim of the current interrupt |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | 5 | Lowest pending pin number |
| irq_valid_o | output | 1 | irq_id_o holds a pending pin |
| spurious_o | output | 1 | Claim made while nothing is pending |

## Verification
The bench builds the block with the default register width of 16, which gives 32 pins. At that width the low and high register halves exist side by side, so a table of writes and readbacks can cover every mapped address, including the gaps between them. The same width lets directed tests set a low-half pin and a high-half pin pending together, which exercises the scan order across the two halves. It also lets the tests place the hold, through and edge cases on pins from both halves.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    FLD_STAT, FLD_EN, FLD_TYPE, FLD_LVL, FLD_HOLD, FLD_FALL, FLD_RISE, FLD_NONE
  } fld_e;

  typedef struct packed {
    fld_e fld;
    logic hi;
  } sel_t;

  function automatic sel_t decode_addr(input logic [ADDR_W-1:0] a);
    sel_t s;
    s.hi = a[1];
    case (a)
      8'h08, 8'h0A: s.fld = FLD_STAT;
      8'h0C, 8'h0E: s.fld = FLD_EN;
      8'h10, 8'h12: s.fld = FLD_TYPE;
      8'h14, 8'h16: s.fld = FLD_LVL;
      8'h18, 8'h1A: s.fld = FLD_HOLD;
      8'h20, 8'h22: s.fld = FLD_FALL;
      8'h24, 8'h26: s.fld = FLD_RISE;
      default:      s.fld = FLD_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= raw_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int REG_W = 16,
  localparam int NPIN = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [NPIN-1:0]   status_i,
  output logic [NPIN-1:0]   clr_o,
  output logic [NPIN-1:0]   en_o,
  output logic [NPIN-1:0]   typ_o,
  output logic [NPIN-1:0]   lvl_o,
  output logic [NPIN-1:0]   hold_o,
  output logic [NPIN-1:0]   fall_o,
  output logic [NPIN-1:0]   rise_o
);
  localparam int NCFG = 6;

  logic [NPIN-1:0] cfg_q [NCFG];
  sel_t            wsel, rsel;

  assign wsel = decode_addr(wr_addr_i);
  assign rsel = decode_addr(rd_addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++) cfg_q[i] <= '0;
    end else if (wr_en_i && wsel.fld != FLD_NONE && wsel.fld != FLD_STAT) begin
      cfg_q[int'(wsel.fld) - 1][int'(wsel.hi) * REG_W +: REG_W] <= wr_data_i;
    end
  end

  always_comb begin
    clr_o = '0;
    if (wr_en_i && wsel.fld == FLD_STAT)
      clr_o[int'(wsel.hi) * REG_W +: REG_W] = wr_data_i;
  end

  always_comb begin
    rd_data_o = '0;
    if (rsel.fld == FLD_STAT)
      rd_data_o = status_i[int'(rsel.hi) * REG_W +: REG_W];
    else if (rsel.fld != FLD_NONE)
      rd_data_o = cfg_q[int'(rsel.fld) - 1][int'(rsel.hi) * REG_W +: REG_W];
  end

  assign en_o   = cfg_q[0];
  assign typ_o  = cfg_q[1];
  assign lvl_o  = cfg_q[2];
  assign hold_o = cfg_q[3];
  assign fall_o = cfg_q[4];
  assign rise_o = cfg_q[5];

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsel.fld == FLD_NONE |-> rd_data_o == '0); // R2
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(typ_o) && $stable(en_o)); // R2
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic typ,
  input  logic act_hi,
  input  logic hold,
  input  logic fall_en,
  input  logic rise_en,
  input  logic clr,
  output logic status_o
);
  logic prev_q, lvl_hit, edge_hit, det;

  assign lvl_hit  = act_hi ? pin_s : ~pin_s;
  assign edge_hit = (rise_en & pin_s & ~prev_q) | (fall_en & ~pin_s & prev_q);
  assign det      = typ ? edge_hit : lvl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      status_o <= 1'b0;
    end else begin
      prev_q   <= pin_s;
      status_o <= hold ? ((status_o & ~clr) | det) : det;
    end
  end

  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hold && status_o && !clr |=> status_o); // R5
  AST_THROUGH_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> status_o == $past(det)); // R6
  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    typ && !hold && $stable(pin_s) |=> !status_o); // R4
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
  parameter int NPIN = 32,
  localparam int ID_W = $clog2(NPIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pend_i,
  output logic [ID_W-1:0] id_o,
  output logic            valid_o
);
  always_comb begin
    id_o    = '0;
    valid_o = 1'b0;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        id_o    = ID_W'(i);
        valid_o = 1'b1;
      end
    end
  end

  AST_ID_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> pend_i[id_o]); // R8
  AST_ID_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (pend_i & ((NPIN'(1) << id_o) - NPIN'(1))) == '0); // R8
  AST_NONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> pend_i == '0); // R8
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int REG_W = 16,
  localparam int NPIN = 2 * REG_W,
  localparam int ID_W = $clog2(NPIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              claim_i,
  output logic              irq_o,
  output logic [ID_W-1:0]   irq_id_o,
  output logic              irq_valid_o,
  output logic              spurious_o
);
  logic [NPIN-1:0] pin_s, status, clr, en, typ, lvl, hold, fall, rise, pend;

  gpio_irq_sync #(.WIDTH(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .sync_o(pin_s)
  );

  gpio_irq_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .status_i(status), .clr_o(clr),
    .en_o(en), .typ_o(typ), .lvl_o(lvl), .hold_o(hold), .fall_o(fall), .rise_o(rise)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_cell
    gpio_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[p]),
      .typ(typ[p]), .act_hi(lvl[p]), .hold(hold[p]),
      .fall_en(fall[p]), .rise_en(rise[p]), .clr(clr[p]),
      .status_o(status[p])
    );
  end

  assign pend  = status & en;
  assign irq_o = |pend;

  gpio_irq_prio #(.NPIN(NPIN)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .id_o(irq_id_o), .valid_o(irq_valid_o)
  );

  assign spurious_o = claim_i & ~irq_valid_o;

  AST_IRQ_MATCHES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == irq_valid_o); // R7
  AST_SPURIOUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spurious_o |-> !irq_o && claim_i); // R9
endmodule

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        claim = 1'b0;
  logic        irq, irq_valid, spurious;
  logic [4:0]  irq_id;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_unit i_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pins),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .claim_i(claim),
    .irq_o(irq), .irq_id_o(irq_id), .irq_valid_o(irq_valid), .spurious_o(spurious)
  );

  // {address, write data, expected readback}
  localparam logic [39:0] VEC [17] = '{
    {8'h08, 16'hFFFF, 16'hFFFF}, {8'h0A, 16'h0000, 16'hFFFF},
    {8'h0C, 16'h1234, 16'h1234}, {8'h0E, 16'h8001, 16'h8001},
    {8'h10, 16'h00FF, 16'h00FF}, {8'h12, 16'hF00F, 16'hF00F},
    {8'h14, 16'h0F0F, 16'h0F0F}, {8'h16, 16'h3C3C, 16'h3C3C},
    {8'h18, 16'h5555, 16'h5555}, {8'h1A, 16'hAAAA, 16'hAAAA},
    {8'h20, 16'h0101, 16'h0101}, {8'h22, 16'h8080, 16'h8080},
    {8'h24, 16'h7E7E, 16'h7E7E}, {8'h26, 16'h1111, 16'h1111},
    {8'h1C, 16'hABCD, 16'h0000}, {8'h09, 16'hFFFF, 16'h0000},
    {8'h2A, 16'h1234, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic do_reset();
    pins = '0;
    @(negedge clk); rst_n = 1'b0;
    step(2); rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    // R1: reset state, read while reset is held
    step(2);
    rd(8'h08, d); chk("R1 status lo", d, 0);
    rd(8'h26, d); chk("R1 rise hi", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 valid", irq_valid, 0);
    rst_n = 1'b1;

    // R2: register map table
    for (int i = 0; i < 17; i++) begin
      wr(VEC[i][39:32], VEC[i][31:16]);
      rd(VEC[i][39:32], d);
      chk($sformatf("R2 addr %h", VEC[i][39:32]), d, VEC[i][15:0]);
    end
    rd(8'h0C, d); chk("R2 enable kept after unmapped writes", d, 16'h1234);

    // R3 + R10: level active-high pin 3
    do_reset();
    wr(8'h14, 16'h0008); wr(8'h0C, 16'h0008);
    step(2); chk("R3 inactive level", irq, 0);
    pins[3] = 1'b1;
    step(2); chk("R10 not before third edge", irq, 0);
    step(1); chk("R10 irq at third edge", irq, 1);
    chk("R3 id pin 3", irq_id, 3);
    pins[3] = 1'b0;
    step(3); chk("R3 level drop clears through status", irq, 0);

    // R3: active-low level pin 17 (high half bit 1)
    do_reset();
    wr(8'h0E, 16'h0002);
    chk("R3 active-low pending", irq, 1);
    chk("R3 id pin 17", irq_id, 17);
    pins[17] = 1'b1;
    step(3); chk("R3 active-low released", irq, 0);

    // R4 + R5: hold, rising only, pin 5
    do_reset();
    wr(8'h10, 16'h0020); wr(8'h24, 16'h0020); wr(8'h18, 16'h0020);
    wr(8'h08, 16'h0020); wr(8'h0C, 16'h0020);
    chk("R4 no edge yet", irq, 0);
    pins[5] = 1'b1;
    step(3); chk("R4 rising detected", irq, 1);
    chk("R4 id pin 5", irq_id, 5);
    pins[5] = 1'b0;
    step(4); chk("R5 sticky after input falls", irq, 1);
    wr(8'h08, 16'h0000);
    rd(8'h08, d); chk("R5 write 0 keeps bit", d[5], 1);
    wr(8'h08, 16'h0020);
    chk("R5 write 1 clears", irq, 0);
    rd(8'h08, d); chk("R5 status bit cleared", d[5], 0);

    // R4: hold, falling only, pin 20 (high half bit 4)
    do_reset();
    wr(8'h12, 16'h0010); wr(8'h22, 16'h0010); wr(8'h1A, 16'h0010);
    wr(8'h0A, 16'h0010); wr(8'h0E, 16'h0010);
    pins[20] = 1'b1;
    step(4); chk("R4 rising ignored when disabled", irq, 0);
    rd(8'h0A, d); chk("R4 no status on rising", d[4], 0);
    pins[20] = 1'b0;
    step(3); chk("R4 falling detected", irq, 1);
    chk("R4 id pin 20", irq_id, 20);

    // R4: both edges, pin 0
    do_reset();
    wr(8'h10, 16'h0001); wr(8'h20, 16'h0001); wr(8'h24, 16'h0001);
    wr(8'h18, 16'h0001); wr(8'h08, 16'h0001); wr(8'h0C, 16'h0001);
    pins[0] = 1'b1;
    step(3); chk("R4 both: rising", irq, 1);
    wr(8'h08, 16'h0001);
    chk("R4 both: cleared", irq, 0);
    pins[0] = 1'b0;
    step(3); chk("R4 both: falling", irq, 1);

    // R6: through edge pulse, pin 9
    do_reset();
    wr(8'h10, 16'h0200); wr(8'h24, 16'h0200); wr(8'h0C, 16'h0200);
    pins[9] = 1'b1;
    step(3); chk("R6 pulse high", irq, 1);
    step(1); chk("R6 pulse one cycle", irq, 0);

    // R7 + R8 + R9: priority across halves
    do_reset();
    wr(8'h14, 16'h0004); wr(8'h16, 16'h0004);
    wr(8'h0C, 16'h0004); wr(8'h0E, 16'h0004);
    rd(8'h08, d); chk("R7 unenabled status set", d, 16'hFFFB);
    chk("R7 masked status gives no irq", irq, 0);
    claim = 1'b1; #1 chk("R9 spurious when idle", spurious, 1);
    pins[2] = 1'b1; pins[18] = 1'b1;
    step(3); chk("R8 low half wins", irq_id, 2);
    chk("R8 valid", irq_valid, 1);
    chk("R9 no spurious when pending", spurious, 0);
    claim = 1'b0;
    wr(8'h0C, 16'h0000);
    chk("R8 high half after low masked", irq_id, 18);
    chk("R7 irq from high half", irq, 1);
    wr(8'h0E, 16'h0000);
    chk("R7 all masked", irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule